// File: doc/BRIEF.md
# Iterative AES-128 Block Engine with Key Derivation

This block encrypts and decrypts single 128-bit blocks under a 128-bit key, one round per clock. Software writes a key and a two-bit operation code while the engine is disabled, then raises the enable. In the three block operations the engine takes four 32-bit words on a valid/ready input stream, computes, raises a completion flag and offers four 32-bit result words on a valid/ready output stream. In the derivation operation no data is taken. The engine expands the stored cipher key to its final round key and writes that key back over the key register, so later decryptions start from it.

Decryption runs the inverse rounds and regenerates the round keys backwards from the final round key, so no schedule storage is needed. The combined operation performs the derivation into a working register and then decrypts, leaving the stored key untouched. Both streams use the same rule: a word moves on a clock edge where valid and ready are both high. The input side withholds ready for one cycle after every accepted word. A producer may hold valid high and simply waits. The output side keeps its word stable while ready is low.

Top module: `aes128_iter_core`

## Requirements
- R1: The operation code is 00 encrypt, 01 derive key, 10 decrypt with stored derived key, 11 derive then decrypt. A code write with `en_i` high has no effect on later behaviour.
- R2: `key_o` always shows the key register. A key write with `en_i` high leaves it unchanged.
- R3: In the block operations `din_ready_o` is high in the input phase and drops for exactly one cycle after each accepted word. The first word supplies bits 127:96 of the block and the fourth supplies bits 31:0.
- R4: Encrypt: `ccf_o` rises 10 clock edges after the edge that accepts the fourth word, and the result is the AES-128 ciphertext of the block.
- R5: Derive: `din_ready_o` stays low. Eleven edges after the first edge that samples `en_i` high, `ccf_o` rises and `key_o` holds the round-10 key of the previous key.
- R6: Decrypt (10): the key register is taken as the round-10 key. `ccf_o` rises 10 edges after the fourth word, and the result is the plaintext.
- R7: Derive then decrypt (11): `ccf_o` rises 20 edges after the fourth word, the result is the plaintext of the block under the stored cipher key, and the key register is not changed.
- R8: `dout_valid_o` is high only while `ccf_o` is set and fewer than four result words have been taken. Words come out most significant first and advance on valid and ready. With ready low, the word holds.
- R9: `ccf_clr_i` clears the flag. While the flag is set, `din_ready_o` stays low, and after a block clear the engine returns to the input phase.
- R10: Lowering `en_i` aborts any operation. On the next edge the flag, `din_ready_o` and `dout_valid_o` go low, and partial input is discarded.
- R11: After reset the key register is zero, the code is 00, and `ccf_o`, `din_ready_o` and `dout_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Engine enable (level) |
| mode_we_i | input | 1 | Operation code write strobe |
| mode_i | input | 2 | Operation code |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 128 | Key write data |
| key_o | output | 128 | Key register contents |
| din_valid_i | input | 1 | Input word valid |
| din_ready_o | output | 1 | Input word ready |
| din_data_i | input | 32 | Input word |
| dout_valid_o | output | 1 | Result word valid |
| dout_ready_i | input | 1 | Result word ready |
| dout_data_o | output | 32 | Result word |
| ccf_o | output | 1 | Computation complete flag |
| ccf_clr_i | input | 1 | Write-1 clear of the flag |

## Verification
The checker watches the control rules on every cycle: the code and key stay frozen while enabled, the one-cycle input gap appears, input is refused while the flag is set or a derivation is selected, result words hold under back-pressure, and an abort takes effect. The cryptographic results, the round-10 key written back, the exact latencies of each operation and the encrypt-then-decrypt round trip can only be shown by the bench's scenarios, which compare every cycle against a behavioural model that holds known-answer vectors.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int AES_WORD_W = 32;
  localparam int AES_WORDS  = 4;
  localparam int AES_BLK_W  = AES_WORD_W * AES_WORDS;
  localparam int AES_ROUNDS = 10;
  localparam int AES_RND_W  = $clog2(AES_ROUNDS + 1);

  typedef enum logic [1:0] {
    OP_ENC    = 2'b00,
    OP_DERIVE = 2'b01,
    OP_DEC    = 2'b10,
    OP_DDEC   = 2'b11
  } op_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_IN, PH_ENC, PH_DER, PH_DEC, PH_OUT, PH_HOLD
  } phase_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa, bb;
    p = 8'h00; aa = a; bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) p = p ^ aa;
      aa = xt(aa);
      bb = bb >> 1;
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] a2, a3, a6, a12, a15, a30, a60, a120, a240, a252;
    a2   = gmul(a, a);
    a3   = gmul(a2, a);
    a6   = gmul(a3, a3);
    a12  = gmul(a6, a6);
    a15  = gmul(a12, a3);
    a30  = gmul(a15, a15);
    a60  = gmul(a30, a30);
    a120 = gmul(a60, a60);
    a240 = gmul(a120, a120);
    a252 = gmul(a240, a12);
    return gmul(a252, a2);
  endfunction

  function automatic logic [7:0] rl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_sub(input logic [7:0] a);
    logic [7:0] b;
    b = ginv(a);
    return b ^ rl8(b, 1) ^ rl8(b, 2) ^ rl8(b, 3) ^ rl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sub(input logic [7:0] s);
    return ginv(rl8(s, 1) ^ rl8(s, 3) ^ rl8(s, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] sub_rot(input logic [31:0] w);
    logic [31:0] r;
    r = {w[23:0], w[31:24]};
    return {fwd_sub(r[31:24]), fwd_sub(r[23:16]), fwd_sub(r[15:8]), fwd_sub(r[7:0])};
  endfunction

  function automatic logic [31:0] mix_fwd(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  function automatic logic [31:0] mix_inv(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gmul(a0,8'h0e) ^ gmul(a1,8'h0b) ^ gmul(a2,8'h0d) ^ gmul(a3,8'h09),
            gmul(a0,8'h09) ^ gmul(a1,8'h0e) ^ gmul(a2,8'h0b) ^ gmul(a3,8'h0d),
            gmul(a0,8'h0d) ^ gmul(a1,8'h09) ^ gmul(a2,8'h0e) ^ gmul(a3,8'h0b),
            gmul(a0,8'h0b) ^ gmul(a1,8'h0d) ^ gmul(a2,8'h09) ^ gmul(a3,8'h0e)};
  endfunction

  // round constant of schedule step idx (1-based)
  function automatic logic [7:0] rcon_of(input logic [AES_RND_W-1:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < AES_ROUNDS; i++)
      if (i < int'(idx)) r = xt(r);
    return r;
  endfunction
endpackage

// File: rtl/aes128_enc_round.sv
module aes128_enc_round
  import aes128_pkg::*;
(
  input  logic [AES_BLK_W-1:0] st_i,
  input  logic [AES_BLK_W-1:0] rk_i,
  input  logic                 last_i,
  output logic [AES_BLK_W-1:0] st_o
);
  logic [AES_BLK_W-1:0] shifted, mixed;

  for (genvar c = 0; c < AES_WORDS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c + r) % 4) + r;
      assign shifted[AES_BLK_W-1-8*DST -: 8] = fwd_sub(st_i[AES_BLK_W-1-8*SRC -: 8]);
    end
    assign mixed[AES_BLK_W-1-AES_WORD_W*c -: AES_WORD_W] =
      mix_fwd(shifted[AES_BLK_W-1-AES_WORD_W*c -: AES_WORD_W]);
  end

  assign st_o = (last_i ? shifted : mixed) ^ rk_i;
endmodule

// File: rtl/aes128_dec_round.sv
module aes128_dec_round
  import aes128_pkg::*;
(
  input  logic [AES_BLK_W-1:0] st_i,
  input  logic [AES_BLK_W-1:0] rk_i,
  input  logic                 last_i,
  output logic [AES_BLK_W-1:0] st_o
);
  logic [AES_BLK_W-1:0] unshifted, keyed, unmixed;

  for (genvar c = 0; c < AES_WORDS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c - r + 4) % 4) + r;
      assign unshifted[AES_BLK_W-1-8*DST -: 8] = inv_sub(st_i[AES_BLK_W-1-8*SRC -: 8]);
    end
    assign unmixed[AES_BLK_W-1-AES_WORD_W*c -: AES_WORD_W] =
      mix_inv(keyed[AES_BLK_W-1-AES_WORD_W*c -: AES_WORD_W]);
  end

  assign keyed = unshifted ^ rk_i;
  assign st_o  = last_i ? keyed : unmixed;
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
  import aes128_pkg::*;
#(
  parameter bit REVERSE = 1'b0
) (
  input  logic [AES_BLK_W-1:0] rk_i,
  input  logic [7:0]           rcon_i,
  output logic [AES_BLK_W-1:0] rk_o
);
  logic [AES_WORD_W-1:0] a0, a1, a2, a3;
  assign {a0, a1, a2, a3} = rk_i;

  if (REVERSE) begin : g_rev
    logic [AES_WORD_W-1:0] b3;
    assign b3   = a2 ^ a3;
    assign rk_o = {a0 ^ sub_rot(b3) ^ {rcon_i, 24'h0}, a0 ^ a1, a1 ^ a2, b3};
  end else begin : g_fwd
    logic [AES_WORD_W-1:0] n0, n1, n2;
    assign n0   = a0 ^ sub_rot(a3) ^ {rcon_i, 24'h0};
    assign n1   = a1 ^ n0;
    assign n2   = a2 ^ n1;
    assign rk_o = {n0, n1, n2, a3 ^ n2};
  end
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
  import aes128_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         mode_we_i,
  input  logic [1:0]   mode_i,
  input  logic         key_we_i,
  input  logic [127:0] key_i,
  output logic [127:0] key_o,
  input  logic         din_valid_i,
  output logic         din_ready_o,
  input  logic [31:0]  din_data_i,
  output logic         dout_valid_o,
  input  logic         dout_ready_i,
  output logic [31:0]  dout_data_o,
  output logic         ccf_o,
  input  logic         ccf_clr_i
);
  localparam int CNT_W = $clog2(AES_WORDS);
  localparam int BUF_W = AES_BLK_W - AES_WORD_W;
  localparam logic [AES_RND_W-1:0] RND_LAST  = AES_RND_W'(AES_ROUNDS);
  localparam logic [AES_RND_W-1:0] RND_FIRST = AES_RND_W'(1);
  localparam logic [CNT_W-1:0]     WORD_LAST = CNT_W'(AES_WORDS - 1);

  phase_t                 phase_q;
  logic [1:0]             mode_q;
  logic [AES_BLK_W-1:0]   key_q, st_q, rk_q;
  logic [AES_RND_W-1:0]   round_q;
  logic [CNT_W-1:0]       wcnt_q;
  logic [CNT_W:0]         ocnt_q;
  logic [BUF_W-1:0]       buf_q;
  logic                   gap_q, ccf_q;

  logic [AES_BLK_W-1:0]   blk, enc_out, dec_out, rk_fwd, rk_rev;
  logic [7:0]             rcon_w;
  logic                   accept, out_take;

  assign rcon_w = rcon_of(round_q);
  assign blk    = {buf_q, din_data_i};

  aes128_key_step #(.REVERSE(1'b0)) u_kfwd (.rk_i(rk_q), .rcon_i(rcon_w), .rk_o(rk_fwd));
  aes128_key_step #(.REVERSE(1'b1)) u_krev (.rk_i(rk_q), .rcon_i(rcon_w), .rk_o(rk_rev));
  aes128_enc_round u_enc (.st_i(st_q), .rk_i(rk_fwd), .last_i(round_q == RND_LAST),  .st_o(enc_out));
  aes128_dec_round u_dec (.st_i(st_q), .rk_i(rk_rev), .last_i(round_q == RND_FIRST), .st_o(dec_out));

  assign din_ready_o  = (phase_q == PH_IN) && !gap_q;
  assign dout_valid_o = (phase_q == PH_OUT) && !ocnt_q[CNT_W];
  assign accept       = din_valid_i && din_ready_o;
  assign out_take     = dout_valid_o && dout_ready_i;
  assign ccf_o        = ccf_q;
  assign key_o        = key_q;

  always_comb begin
    dout_data_o = '0;
    for (int i = 0; i < AES_WORDS; i++)
      if (ocnt_q[CNT_W-1:0] == CNT_W'(i))
        dout_data_o = st_q[AES_BLK_W-1-AES_WORD_W*i -: AES_WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= OP_ENC;
      key_q   <= '0;
      st_q    <= '0;
      rk_q    <= '0;
      round_q <= '0;
      wcnt_q  <= '0;
      ocnt_q  <= '0;
      buf_q   <= '0;
      gap_q   <= 1'b0;
      ccf_q   <= 1'b0;
    end else if (!en_i) begin
      if (mode_we_i) mode_q <= mode_i;
      if (key_we_i)  key_q  <= key_i;
      phase_q <= PH_IDLE;
      ccf_q   <= 1'b0;
      gap_q   <= 1'b0;
      wcnt_q  <= '0;
      ocnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (mode_q == OP_DERIVE) begin
            rk_q    <= key_q;
            round_q <= RND_FIRST;
            phase_q <= PH_DER;
          end else begin
            wcnt_q  <= '0;
            gap_q   <= 1'b0;
            phase_q <= PH_IN;
          end
        end
        PH_IN: begin
          if (accept) begin
            gap_q  <= 1'b1;
            buf_q  <= {buf_q[BUF_W-AES_WORD_W-1:0], din_data_i};
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == WORD_LAST) begin
              rk_q <= key_q;
              case (mode_q)
                OP_ENC: begin
                  st_q <= blk ^ key_q; round_q <= RND_FIRST; phase_q <= PH_ENC;
                end
                OP_DEC: begin
                  st_q <= blk ^ key_q; round_q <= RND_LAST; phase_q <= PH_DEC;
                end
                default: begin
                  st_q <= blk; round_q <= RND_FIRST; phase_q <= PH_DER;
                end
              endcase
            end
          end else begin
            gap_q <= 1'b0;
          end
        end
        PH_ENC: begin
          st_q <= enc_out;
          rk_q <= rk_fwd;
          round_q <= round_q + 1'b1;
          if (round_q == RND_LAST) begin
            ccf_q   <= 1'b1;
            ocnt_q  <= '0;
            phase_q <= PH_OUT;
          end
        end
        PH_DER: begin
          rk_q <= rk_fwd;
          if (round_q != RND_LAST) begin
            round_q <= round_q + 1'b1;
          end else if (mode_q == OP_DERIVE) begin
            key_q   <= rk_fwd;
            ccf_q   <= 1'b1;
            phase_q <= PH_HOLD;
          end else begin
            st_q    <= st_q ^ rk_fwd;
            round_q <= RND_LAST;
            phase_q <= PH_DEC;
          end
        end
        PH_DEC: begin
          st_q <= dec_out;
          rk_q <= rk_rev;
          round_q <= round_q - 1'b1;
          if (round_q == RND_FIRST) begin
            ccf_q   <= 1'b1;
            ocnt_q  <= '0;
            phase_q <= PH_OUT;
          end
        end
        PH_OUT: begin
          if (out_take) ocnt_q <= ocnt_q + 1'b1;
          if (ccf_clr_i) begin
            ccf_q   <= 1'b0;
            gap_q   <= 1'b0;
            wcnt_q  <= '0;
            phase_q <= PH_IN;
          end
        end
        PH_HOLD: begin
          if (ccf_clr_i) ccf_q <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aes128_iter_core_chk.sv
module aes128_iter_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic [1:0]   mode_q,
  input logic [127:0] key_o,
  input logic         din_valid_i,
  input logic         din_ready_o,
  input logic         dout_valid_o,
  input logic         dout_ready_i,
  input logic [31:0]  dout_data_o,
  input logic         ccf_o,
  input logic         ccf_clr_i
);
  p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(mode_q));

  p_key_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_q != 2'b01) |=> $stable(key_o));

  p_input_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid_i && din_ready_o) |=> !din_ready_o);

  p_derive_no_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> !din_ready_o);

  p_dout_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid_o |-> ccf_o);

  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid_o && !dout_ready_i && !ccf_clr_i && en_i) |=> (dout_valid_o && $stable(dout_data_o)));

  p_flag_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ccf_o |-> !din_ready_o);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!ccf_o && !din_ready_o && !dout_valid_o));
endmodule

bind aes128_iter_core aes128_iter_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_q(mode_q), .key_o(key_o),
  .din_valid_i(din_valid_i), .din_ready_o(din_ready_o),
  .dout_valid_o(dout_valid_o), .dout_ready_i(dout_ready_i), .dout_data_o(dout_data_o),
  .ccf_o(ccf_o), .ccf_clr_i(ccf_clr_i)
);

// File: tb/aes128_iter_core_test.sv
module aes128_iter_core_test;
  localparam logic [127:0] K1  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] RK1 = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] K2  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] RK2 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic mode_we = 1'b0, key_we = 1'b0, din_valid = 1'b0, dout_ready = 1'b0, ccf_clr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic [127:0] key_in = '0;
  logic [31:0] din_data = '0;
  logic [127:0] key_o;
  logic din_ready, dout_valid, ccf;
  logic [31:0] dout_data;

  int compared = 0, mismatched = 0, cyc = 0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  aes128_iter_core uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_we_i(mode_we), .mode_i(mode_in),
    .key_we_i(key_we), .key_i(key_in), .key_o(key_o),
    .din_valid_i(din_valid), .din_ready_o(din_ready), .din_data_i(din_data),
    .dout_valid_o(dout_valid), .dout_ready_i(dout_ready), .dout_data_o(dout_data),
    .ccf_o(ccf), .ccf_clr_i(ccf_clr)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int ph = 0;               // 0 idle, 1 input, 2 busy, 3 output, 4 holding
  logic [1:0] m_mode = 2'b00;
  logic [127:0] m_key = '0, m_res = '0;
  bit m_known = 1'b0, m_gap = 1'b0, m_ccf = 1'b0;
  int m_cnt = 0, m_oc = 0;
  logic [31:0] m_q[$];

  function automatic logic [127:0] kat(input logic [1:0] m, input logic [127:0] k,
                                       input logic [127:0] b, output bit known);
    known = 1'b1;
    if (m == 2'b00 && k == K1 && b == P1) return C1;
    if (m == 2'b00 && k == K2 && b == P2) return C2;
    if (m == 2'b10 && k == RK1 && b == C1) return P1;
    if (m == 2'b10 && k == RK2 && b == C2) return P2;
    if (m == 2'b11 && k == K1 && b == C1) return P1;
    if (m == 2'b11 && k == K2 && b == C2) return P2;
    known = 1'b0;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_mode = 2'b00; m_key = '0; m_gap = 0; m_ccf = 0; m_q.delete();
    end else if (!en) begin
      if (mode_we) m_mode = mode_in;
      if (key_we)  m_key  = key_in;
      ph = 0; m_ccf = 0; m_gap = 0; m_q.delete();
    end else begin
      case (ph)
        0: if (m_mode == 2'b01) begin ph = 2; m_cnt = 11 - 1; end
           else begin ph = 1; m_gap = 0; m_q.delete(); end
        1: if (din_valid && !m_gap) begin
             m_q.push_back(din_data);
             m_gap = 1;
             if (m_q.size() == 4) begin
               m_res = kat(m_mode, m_key, {m_q[0], m_q[1], m_q[2], m_q[3]}, m_known);
               m_cnt = (m_mode == 2'b11) ? 20 : 10;
               ph = 2;
             end
           end else m_gap = 0;
        2: begin
             m_cnt--;
             if (m_cnt == 0) begin
               m_ccf = 1;
               if (m_mode == 2'b01) begin
                 if (m_key == K1) m_key = RK1;
                 else if (m_key == K2) m_key = RK2;
                 else m_key = 'x;
                 ph = 4;
               end else begin ph = 3; m_oc = 0; end
             end
           end
        3: begin
             if (dout_ready && m_oc < 4) m_oc++;
             if (ccf_clr) begin m_ccf = 0; ph = 1; m_gap = 0; m_q.delete(); end
           end
        default: if (ccf_clr) m_ccf = 0;
      endcase
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_rdy, e_dv;
      e_rdy = (ph == 1) && !m_gap;
      e_dv  = (ph == 3) && (m_oc < 4);
      check(din_ready === e_rdy, "R3 din_ready", 128'(din_ready), 128'(e_rdy));
      check(dout_valid === e_dv, "R8 dout_valid", 128'(dout_valid), 128'(e_dv));
      check(ccf === m_ccf, "R9 ccf (latency R4/R5/R6/R7)", 128'(ccf), 128'(m_ccf));
      if (!$isunknown(m_key))
        check(key_o === m_key, "R2 key_o", key_o, m_key);
      if (e_dv && m_known)
        check(dout_data === m_res[127-32*m_oc -: 32], "R8 dout_data",
              128'(dout_data), 128'(m_res[127-32*m_oc -: 32]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog (all R) actual=%0d expected<=%0d cycles", cyc, 20000);
      summary();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put_mode(input logic [1:0] m);
    mode_in = m; mode_we = 1'b1; tick(); mode_we = 1'b0;
  endtask

  task automatic put_key(input logic [127:0] k);
    key_in = k; key_we = 1'b1; tick(); key_we = 1'b0;
  endtask

  task automatic send(input logic [127:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      bit took;
      din_data = b[127-32*i -: 32];
      din_valid = 1'b1;
      do begin took = din_ready; tick(); end while (!took);
    end
    din_valid = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 60 && !ccf; i++) tick();
  endtask

  task automatic receive(input bit throttle, output logic [127:0] res);
    int got = 0;
    res = '0;
    for (int i = 0; i < 40 && got < 4; i++) begin
      dout_ready = throttle ? i[0] : 1'b1;
      #0;
      if (dout_valid && dout_ready) begin
        res[127-32*got -: 32] = dout_data;
        got++;
      end
      tick();
    end
    dout_ready = 1'b0;
  endtask

  task automatic clear_flag();
    ccf_clr = 1'b1; tick(); ccf_clr = 1'b0;
  endtask

  initial begin
    logic [127:0] r;
    repeat (3) tick();
    cmp_en = 1'b1;
    rst_n = 1'b1;
    tick();
    // R11: reset state
    check(key_o == 0 && !ccf && !din_ready && !dout_valid, "R11 reset state",
          {key_o[123:0], ccf, din_ready, dout_valid, 1'b0}, 128'h0);

    // R4: encrypt, back-to-back valid exercises the input gap (R3)
    put_mode(2'b00); put_key(K1);
    en = 1'b1;
    send(P1, 4); wait_flag();
    receive(1'b0, r);
    check(r == C1, "R4 encrypt result", r, C1);
    check(!din_ready, "R9 input refused while flag set", 128'(din_ready), 128'h0);
    clear_flag();

    // R1/R2: code and key writes while enabled are ignored
    mode_in = 2'b10; mode_we = 1'b1; key_in = K2; key_we = 1'b1; tick();
    mode_we = 1'b0; key_we = 1'b0;
    check(key_o == K1, "R2 key write ignored when enabled", key_o, K1);
    send(P1, 4); wait_flag();
    receive(1'b1, r);
    check(r == C1, "R1 code write ignored, still encrypting", r, C1);
    clear_flag();
    en = 1'b0; tick();

    // R5: key derivation writes back the round-10 key
    put_mode(2'b01);
    en = 1'b1; wait_flag();
    check(key_o == RK1, "R5 derived key", key_o, RK1);
    clear_flag();
    en = 1'b0; tick();

    // R6: decrypt with derived key
    put_mode(2'b10);
    en = 1'b1;
    send(C1, 4); wait_flag();
    receive(1'b1, r);
    check(r == P1, "R6 decrypt result", r, P1);
    clear_flag();
    en = 1'b0; tick();

    // R7: derive then decrypt leaves the key register alone
    put_key(K1); put_mode(2'b11);
    en = 1'b1;
    send(C1, 4); wait_flag();
    receive(1'b0, r);
    check(r == P1, "R7 derive-and-decrypt result", r, P1);
    check(key_o == K1, "R7 key register unchanged", key_o, K1);
    clear_flag();
    en = 1'b0; tick();

    // encrypt then decrypt round trip with a second key
    put_key(K2); put_mode(2'b00);
    en = 1'b1; send(P2, 4); wait_flag(); receive(1'b0, r);
    check(r == C2, "R4 encrypt second vector", r, C2);
    clear_flag(); en = 1'b0; tick();
    put_mode(2'b01); en = 1'b1; wait_flag();
    check(key_o == RK2, "R5 derived key second vector", key_o, RK2);
    clear_flag(); en = 1'b0; tick();
    put_mode(2'b10); en = 1'b1; send(r, 4); wait_flag(); receive(1'b1, r);
    check(r == P2, "R6 round trip returns plaintext", r, P2);
    clear_flag(); en = 1'b0; tick();

    // R10: abort with partial input, then a clean block
    put_key(K2); put_mode(2'b00);
    en = 1'b1; send(P1, 2);
    en = 1'b0; tick();
    check(!ccf && !din_ready && !dout_valid, "R10 abort clears outputs",
          {125'h0, ccf, din_ready, dout_valid}, 128'h0);
    en = 1'b1;
    send(P2, 4); wait_flag(); receive(1'b0, r);
    check(r == C2, "R10 partial input discarded", r, C2);
    clear_flag();
    en = 1'b0;
    repeat (3) tick();
    summary();
  end
endmodule